// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block sits beside a small processor core and decides which of five interrupt request lines is serviced next. One line is non-maskable and always wins. The other four are maskable: a global enable bit gates all four, and three of them also have their own mask bits. Among the maskable lines the order is fixed: the edge-latched line first, then the upper level line, then the lower level line, and the external-vector line last.

Requests are looked at only when the core pulses a one-cycle instruction-boundary strobe. When a request wins at a boundary, the block raises a one-cycle "taken" pulse with a fixed 16-bit vector address on the next cycle and clears the global enable, so a service routine runs with maskable requests shut off until software enables them again. For the external-vector line the block pulses an acknowledge instead, so that the requesting device can place its own opcode. A mask-write command loads the three mask bits and can discard a latched edge request. A status-read command takes a snapshot of the masks, the enable bit and the pending requests.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `take_o` and `ack_o` are 0, the global enable is 0, all three mask bits are 1 (masked), and `stat_o` reads 0x00. A status read straight after reset returns 0x07.
- R2: The non-maskable line `nmi_i` is latched on a rising edge and then serviced at the next boundary whatever the enable and mask state, with vector 0x0024. One assertion gives exactly one service. If the line falls before a boundary, the request is dropped.
- R3: Priority is fixed, highest first: non-maskable, edge line (vector 0x003C), upper level line (0x0034), lower level line (0x002C), external line.
- R4: The four maskable lines are serviced only while the global enable is 1. `ien_set_i` sets it and `ien_clr_i` clears it, each taking effect on the next cycle.
- R5: When the external line `ext_i` is serviced, `ack_o` pulses for the same cycle as `take_o` and `vec_o` is 0x0000. `ack_o` stays 0 for every other source.
- R6: A rising edge on `edge_i` sets a pending latch that stays set after the line falls. The latch clears when that request is serviced, or on a mask write with `mask_din_i[3]`=1. A new rising edge in the same cycle as a clear wins.
- R7: Accepting any interrupt clears the global enable. If `ien_set_i` arrives in the same cycle as the acceptance, the enable still ends at 0.
- R8: `mask_wr_i` loads the masks from `mask_din_i` as follows: bit0 masks the lower level line, bit1 masks the upper level line, bit2 masks the edge line (1 = masked). A masked line is never serviced, but the edge latch still captures edges while that line is masked.
- R9: Requests are sampled only in a cycle with `boundary_i`=1. `take_o` rises on the cycle after that boundary and lasts exactly one cycle.
- R10: `mask_rd_i` loads `stat_o` on the next cycle with: [2:0] masks, [3] global enable, [4] lower level line, [5] upper level line, [6] edge pending, [7] non-maskable pending.
- R11: The two level lines are not latched. A level request that goes away before a boundary is not serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Non-maskable request, edge latched, must stay high |
| edge_i | input | 1 | Maskable request, rising-edge latched |
| lvl_hi_i | input | 1 | Maskable level request, upper level |
| lvl_lo_i | input | 1 | Maskable level request, lower level |
| ext_i | input | 1 | Maskable level request, vector supplied externally |
| boundary_i | input | 1 | One-cycle instruction-boundary strobe from the core |
| ien_set_i | input | 1 | Command: set global enable |
| ien_clr_i | input | 1 | Command: clear global enable |
| mask_wr_i | input | 1 | Command: write masks from mask_din_i |
| mask_din_i | input | 4 | Mask bits [2:0], edge-latch clear [3] |
| mask_rd_i | input | 1 | Command: capture status into stat_o |
| take_o | output | 1 | Interrupt accepted, one-cycle pulse |
| vec_o | output | 16 | Vector of the accepted source |
| ack_o | output | 1 | Acknowledge pulse for the external-vector line |
| stat_o | output | 8 | Status snapshot |

## Verification
Two functions can fall in the same cycle: accepting an interrupt, which clears the global enable, and an enable-set command from the core. The bench raises a level request with the enable on, then drives the boundary strobe and the enable-set command in one cycle. It judges the result from a status read, which must show the enable at 0. A second overlap, a new rising edge on the edge line during a latch-clearing mask write, is checked the same way through the pending bit in the status.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_W   = 3;

  // index order is the fixed priority order, 0 = highest
  typedef enum logic [SRC_W-1:0] {
    SRC_NMI  = 3'd0,
    SRC_EDGE = 3'd1,
    SRC_HI   = 3'd2,
    SRC_LO   = 3'd3,
    SRC_EXT  = 3'd4
  } src_e;

  localparam int MSK_LO   = 0;
  localparam int MSK_HI   = 1;
  localparam int MSK_EDGE = 2;
  localparam int MSK_CLR  = 3;
endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
  parameter bit HOLD_REQ = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;
  logic rise;
  logic pend_n;

  assign rise = line_i & ~prev_q;

  generate
    if (HOLD_REQ) begin : g_hold
      always_comb begin
        if (rise)         pend_n = 1'b1;
        else if (clr_i)   pend_n = 1'b0;
        else if (!line_i) pend_n = 1'b0;
        else              pend_n = pend_q;
      end
    end else begin : g_latch
      always_comb begin
        if (rise)       pend_n = 1'b1;
        else if (clr_i) pend_n = 1'b0;
        else            pend_n = pend_q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;

  AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (rst)
    rise |=> pend_q); // R6
  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !rise) |=> !pend_q); // R2
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic found;

  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign any_o = |req_i;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    any_o |-> $onehot(grant_o)); // R3
  AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !any_o |-> (grant_o == '0)); // R3
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_NMI  = 16'h0024,
  parameter logic [ADDR_W-1:0] VEC_EDGE = 16'h003C,
  parameter logic [ADDR_W-1:0] VEC_HI   = 16'h0034,
  parameter logic [ADDR_W-1:0] VEC_LO   = 16'h002C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_i,
  input  logic              edge_i,
  input  logic              lvl_hi_i,
  input  logic              lvl_lo_i,
  input  logic              ext_i,
  input  logic              boundary_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  logic              mask_wr_i,
  input  logic [3:0]        mask_din_i,
  input  logic              mask_rd_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              ack_o,
  output logic [7:0]        stat_o
);
  localparam logic [ADDR_W-1:0] VEC_TBL [NUM_SRC] =
    '{VEC_NMI, VEC_EDGE, VEC_HI, VEC_LO, '0};

  logic              ien_q;
  logic [2:0]        mask_q;
  logic              take_q;
  logic              ack_q;
  logic [ADDR_W-1:0] vec_q;
  logic [7:0]        stat_q;

  logic              nmi_pend;
  logic              edge_pend;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic              any_req;
  logic              accept;
  logic [ADDR_W-1:0] vec_sel;

  // non-maskable line: request dropped if the line falls before service
  irq_edge_cap #(.HOLD_REQ(1'b1)) u_nmi_cap (
    .clk   (clk),
    .rst   (rst),
    .line_i(nmi_i),
    .clr_i (accept & grant[SRC_NMI]),
    .pend_o(nmi_pend)
  );

  // edge line: latched until serviced or cleared by a mask write
  irq_edge_cap #(.HOLD_REQ(1'b0)) u_edge_cap (
    .clk   (clk),
    .rst   (rst),
    .line_i(edge_i),
    .clr_i ((accept & grant[SRC_EDGE]) | (mask_wr_i & mask_din_i[MSK_CLR])),
    .pend_o(edge_pend)
  );

  always_comb begin
    req[SRC_NMI]  = nmi_pend;
    req[SRC_EDGE] = ien_q & edge_pend & ~mask_q[MSK_EDGE];
    req[SRC_HI]   = ien_q & lvl_hi_i  & ~mask_q[MSK_HI];
    req[SRC_LO]   = ien_q & lvl_lo_i  & ~mask_q[MSK_LO];
    req[SRC_EXT]  = ien_q & ext_i;
  end

  irq_arbiter #(.N(NUM_SRC)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req),
    .grant_o(grant),
    .any_o  (any_req)
  );

  assign accept = boundary_i & any_req;

  always_comb begin
    vec_sel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) vec_sel = vec_sel | VEC_TBL[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= 1'b0;
      mask_q <= 3'b111;
      take_q <= 1'b0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
      stat_q <= '0;
    end else begin
      take_q <= accept;
      ack_q  <= accept & grant[SRC_EXT];
      if (accept) vec_q <= vec_sel;

      if (accept)         ien_q <= 1'b0;
      else if (ien_clr_i) ien_q <= 1'b0;
      else if (ien_set_i) ien_q <= 1'b1;

      if (mask_wr_i) mask_q <= mask_din_i[2:0];

      if (mask_rd_i)
        stat_q <= {nmi_pend, edge_pend, lvl_hi_i, lvl_lo_i, ien_q, mask_q};
    end
  end

  assign take_o = take_q;
  assign ack_o  = ack_q;
  assign vec_o  = vec_q;
  assign stat_o = stat_q;

  AST_TAKE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    take_q |-> $past(boundary_i)); // R9
  AST_NMI_UNGATED: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && nmi_pend) |=> (take_q && vec_q == VEC_NMI)); // R2
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && !ien_q && !nmi_pend) |=> !take_q); // R4
  AST_ACCEPT_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    take_q |-> !ien_q); // R7
  AST_ACK_WITH_TAKE: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (take_q && vec_q == '0)); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && !nmi_pend && !ext_i && mask_q == 3'b111) |=> !take_q); // R8
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        nmi_i = 0, edge_i = 0, lvl_hi_i = 0, lvl_lo_i = 0, ext_i = 0;
  logic        boundary_i = 0, ien_set_i = 0, ien_clr_i = 0;
  logic        mask_wr_i = 0, mask_rd_i = 0;
  logic [3:0]  mask_din_i = '0;
  logic        take_o, ack_o;
  logic [15:0] vec_o;
  logic [7:0]  stat_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .nmi_i(nmi_i), .edge_i(edge_i),
    .lvl_hi_i(lvl_hi_i), .lvl_lo_i(lvl_lo_i), .ext_i(ext_i),
    .boundary_i(boundary_i), .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
    .mask_wr_i(mask_wr_i), .mask_din_i(mask_din_i), .mask_rd_i(mask_rd_i),
    .take_o(take_o), .vec_o(vec_o), .ack_o(ack_o), .stat_o(stat_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // strobe a boundary, return the outputs of the following cycle
  task automatic bnd(output logic t, output logic [15:0] v, output logic a);
    boundary_i = 1'b1;
    step();
    boundary_i = 1'b0;
    t = take_o; v = vec_o; a = ack_o;
  endtask

  task automatic rd_stat(output logic [7:0] s);
    mask_rd_i = 1'b1;
    step();
    mask_rd_i = 1'b0;
    s = stat_o;
  endtask

  task automatic wr_mask(input logic [3:0] d);
    mask_wr_i = 1'b1; mask_din_i = d;
    step();
    mask_wr_i = 1'b0; mask_din_i = '0;
  endtask

  task automatic en();
    ien_set_i = 1'b1; step(); ien_set_i = 1'b0;
  endtask

  task automatic edge_pulse();
    edge_i = 1'b1; step(); edge_i = 1'b0; step();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 take at reset", take_o, 0);
    chk("R1 ack at reset", ack_o, 0);
    chk("R1 stat at reset", stat_o, 8'h00);
    rd_stat(s);
    chk("R1 status after reset", s, 8'h07);
  endtask

  task automatic t_nmi();
    logic t, a; logic [15:0] v;
    nmi_i = 1'b1; step();
    bnd(t, v, a);
    chk("R2 nmi taken with enable off", t, 1);
    chk("R2 nmi vector", v, 16'h0024);
    chk("R5 no ack for nmi", a, 0);
    step();
    chk("R9 take one cycle wide", take_o, 0);
    bnd(t, v, a);
    chk("R2 one service per assertion", t, 0);
    nmi_i = 1'b0; step();
    nmi_i = 1'b1; step(); nmi_i = 1'b0; step();
    bnd(t, v, a);
    chk("R2 dropped nmi not served", t, 0);
  endtask

  task automatic t_gate();
    logic t, a; logic [15:0] v; logic [7:0] s;
    wr_mask(4'b0000);
    lvl_lo_i = 1'b1; step();
    bnd(t, v, a);
    chk("R4 no take with enable off", t, 0);
    en();
    bnd(t, v, a);
    chk("R4 take with enable on", t, 1);
    chk("R3 lower level vector", v, 16'h002C);
    rd_stat(s);
    chk("R7 enable cleared by accept", s[3], 0);
    chk("R10 status lower level line", s, 8'h10);
    en(); ien_clr_i = 1'b1; step(); ien_clr_i = 1'b0;
    bnd(t, v, a);
    chk("R4 clear command gates", t, 0);
    lvl_lo_i = 1'b0; step();
  endtask

  task automatic t_prio();
    logic t, a; logic [15:0] v;
    lvl_hi_i = 1; lvl_lo_i = 1; ext_i = 1; edge_pulse();
    en(); bnd(t, v, a);
    chk("R3 edge line first", v, 16'h003C);
    chk("R5 no ack for edge", a, 0);
    en(); bnd(t, v, a);
    chk("R3 upper level second", v, 16'h0034);
    lvl_hi_i = 0;
    en(); bnd(t, v, a);
    chk("R3 lower level third", v, 16'h002C);
    lvl_lo_i = 0;
    en(); bnd(t, v, a);
    chk("R5 external taken", t, 1);
    chk("R5 external ack", a, 1);
    chk("R5 external vector", v, 16'h0000);
    ext_i = 0; step();
    chk("R5 ack one cycle", ack_o, 0);
    lvl_hi_i = 1; nmi_i = 1; en(); step();
    bnd(t, v, a);
    chk("R3 nmi over maskable", v, 16'h0024);
    en(); bnd(t, v, a);
    chk("R3 maskable after nmi", v, 16'h0034);
    nmi_i = 0; lvl_hi_i = 0; step();
  endtask

  task automatic t_edge();
    logic t, a; logic [15:0] v; logic [7:0] s;
    wr_mask(4'b0100);
    edge_pulse();
    rd_stat(s);
    chk("R8 masked edge still latched", s[6], 1);
    en(); bnd(t, v, a);
    chk("R8 masked edge not taken", t, 0);
    wr_mask(4'b0000);
    step(); step();
    bnd(t, v, a);
    chk("R6 latch held after line low", v, 16'h003C);
    chk("R6 take for latched edge", t, 1);
    edge_pulse();
    wr_mask(4'b1000);
    rd_stat(s);
    chk("R6 mask write clears latch", s[6], 0);
    edge_i = 1'b1; mask_wr_i = 1'b1; mask_din_i = 4'b1000;
    step();
    mask_wr_i = 1'b0; mask_din_i = '0; edge_i = 1'b0;
    rd_stat(s);
    chk("R6 new edge beats clear", s[6], 1);
    wr_mask(4'b1000);
  endtask

  task automatic t_boundary();
    logic t, a; logic [15:0] v;
    lvl_lo_i = 1; en();
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R9 no take without strobe", take_o, 0);
    end
    bnd(t, v, a);
    chk("R9 take after strobe", t, 1);
    step();
    chk("R9 take falls", take_o, 0);
    lvl_lo_i = 0; step();
  endtask

  task automatic t_collide();
    logic [7:0] s;
    lvl_lo_i = 1; en();
    boundary_i = 1; ien_set_i = 1;
    step();
    boundary_i = 0; ien_set_i = 0;
    chk("R7 take during set", take_o, 1);
    lvl_lo_i = 0;
    rd_stat(s);
    chk("R7 accept beats set", s[3], 0);
  endtask

  task automatic t_level();
    logic t, a; logic [15:0] v;
    en();
    lvl_hi_i = 1; step(); lvl_hi_i = 0; step();
    bnd(t, v, a);
    chk("R11 dropped level not served", t, 0);
    ien_clr_i = 1; step(); ien_clr_i = 0;
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_nmi();
    t_gate();
    t_prio();
    t_edge();
    t_boundary();
    t_collide();
    t_level();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule